// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

This block models a byte-wide static memory where every word has a shadow copy that survives power loss. While idle it behaves as a plain SRAM. Reads and writes are framed by active-low chip-enable, output-enable and write-enable strobes, and each one is sampled on the rising clock edge. The shadow copy is held in ordinary registers. It is only reached through two bulk transfers. A STORE copies the working array into the shadow array. A RECALL first clears the working array and then reloads it from the shadow array.

Each transfer has two possible triggers. One is an edge on the power status input: a falling edge starts a STORE, and a rising edge (this includes power coming good after reset) starts a RECALL. The other is a software unlock made of six reads to fixed addresses. The first five addresses are common to both transfers, and the sixth address picks STORE or RECALL. A transfer handles one word per clock in each phase. While it runs, `busy` is high and the memory ignores the bus. The depth is a parameter: the full part is 15 address bits, and the default is kept small so that elaboration stays light.

Top module: `nvsram_ctl`

## Requirements
- R1: With `ce_n`=0, `we_n`=0 and `busy`=0, the byte on `dq_i` is written to the word at `addr` on the clock edge.
- R2: `dq_oe` is 1 exactly when `ce_n`=0, `oe_n`=0, `we_n`=1 and `busy`=0. At that time `dq_o` shows the word at `addr`.
- R3: Write-enable takes priority over output-enable. With `we_n`=0 and `oe_n`=0, `dq_oe` stays 0 and the write takes place.
- R4: A falling edge of `pwr_ok` starts a STORE. `busy` goes high after that edge for DEPTH cycles, and each word of the working array is copied into the shadow array.
- R5: A rising edge of `pwr_ok` starts a RECALL. This includes the first rise after reset. `busy` stays high for 2*DEPTH cycles, and afterwards the working array equals the shadow array.
- R6: Reads (`ce_n`=0, `we_n`=1) to the addresses KEY0, KEY1, KEY2, KEY3, KEY4 and then KEY_STORE start a STORE. Each address uses its low AW bits. Idle cycles with `ce_n`=1 between the reads do not break the sequence.
- R7: The same five reads followed by a read of KEY_RECALL start a RECALL.
- R8: Any read or write that does not match the next key aborts the sequence. A mismatching read of KEY0 counts as a new first step.
- R9: While `busy`=1, `dq_oe` stays 0, writes are ignored, and reads do not advance the unlock sequence.
- R10: A RECALL clears the working array before it loads it. A RECALL never modifies the shadow array, so repeated RECALLs return the same data.
- R11: An edge on `pwr_ok` that occurs while `busy`=1 is dropped and starts no transfer later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| addr | input | AW | Word address |
| dq_i | input | DW | Write data |
| dq_o | output | DW | Read data |
| dq_oe | output | 1 | Read data valid; when low the data bus is high impedance |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| pwr_ok | input | 1 | Power status, high when supply is good |
| busy | output | 1 | High while a STORE or RECALL runs |

## Verification
The assertions assume that `pwr_ok` is a clean level, held for at least one clock, and that it sits low through reset so that power-up is seen as a rising edge. They also assume that strobes and address are stable around each clock edge, so that one edge is one access. The stimulus changes every input only on falling clock edges, with the strobes inactive between accesses. It raises `pwr_ok` once after reset, and it lowers and raises `pwr_ok` only at known points, including once during a running transfer.

// File: rtl/nvsram_ctl.sv
module nvsram_ctl #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [15:0] KEY0 = 16'h0E38,
  parameter logic [15:0] KEY1 = 16'h31C7,
  parameter logic [15:0] KEY2 = 16'h03E0,
  parameter logic [15:0] KEY3 = 16'h3C1F,
  parameter logic [15:0] KEY4 = 16'h303F,
  parameter logic [15:0] KEY_STORE = 16'h0FC0,
  parameter logic [15:0] KEY_RECALL = 16'h0C63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          pwr_ok,
  output logic          busy
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] PTR_LAST = {AW{1'b1}};

  typedef enum logic [1:0] {ST_IDLE, ST_STORE, ST_CLEAR, ST_LOAD} st_t;

  logic [DW-1:0] work   [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  st_t           state;
  logic [AW-1:0] ptr;
  logic [2:0]    idx;
  logic          pwr_q;

  function automatic logic [AW-1:0] key_at(input logic [2:0] i);
    case (i)
      3'd0:    return KEY0[AW-1:0];
      3'd1:    return KEY1[AW-1:0];
      3'd2:    return KEY2[AW-1:0];
      3'd3:    return KEY3[AW-1:0];
      default: return KEY4[AW-1:0];
    endcase
  endfunction

  assign busy = (state != ST_IDLE);

  wire acc_rd = !ce_n && we_n && !busy;
  wire acc_wr = !ce_n && !we_n && !busy;

  assign dq_oe = acc_rd && !oe_n;
  assign dq_o  = work[addr];

  wire pwr_fall   = pwr_q && !pwr_ok;
  wire pwr_rise   = !pwr_q && pwr_ok;
  wire step_hit   = acc_rd && (idx < 3'd5) && (addr == key_at(idx));
  wire fin_store  = acc_rd && (idx == 3'd5) && (addr == KEY_STORE[AW-1:0]);
  wire fin_recall = acc_rd && (idx == 3'd5) && (addr == KEY_RECALL[AW-1:0]);
  wire go_store   = !busy && (pwr_fall || fin_store);
  wire go_recall  = !busy && !go_store && (pwr_rise || fin_recall);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ptr   <= '0;
      idx   <= '0;
      pwr_q <= 1'b0;
    end else begin
      pwr_q <= pwr_ok;

      if (busy || go_store || go_recall)
        idx <= '0;
      else if (step_hit)
        idx <= idx + 3'd1;
      else if (acc_rd || acc_wr)
        idx <= (acc_rd && addr == key_at(3'd0)) ? 3'd1 : 3'd0;

      case (state)
        ST_IDLE: begin
          ptr <= '0;
          if (go_store)       state <= ST_STORE;
          else if (go_recall) state <= ST_CLEAR;
        end
        ST_STORE: begin
          ptr <= ptr + 1'b1;
          if (ptr == PTR_LAST) state <= ST_IDLE;
        end
        ST_CLEAR: begin
          ptr <= ptr + 1'b1;
          if (ptr == PTR_LAST) state <= ST_LOAD;
        end
        default: begin
          ptr <= ptr + 1'b1;
          if (ptr == PTR_LAST) state <= ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (acc_wr) work[addr] <= dq_i;
    case (state)
      ST_STORE: shadow[ptr] <= work[ptr];
      ST_CLEAR: work[ptr]   <= '0;
      ST_LOAD:  work[ptr]   <= shadow[ptr];
      default:  ;
    endcase
  end

  // R9
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx == 3'd0);

  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= 3'd5);

  // R4
  start_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ptr == '0);

  // R5
  xfer_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ptr) == PTR_LAST && $past(state) != ST_CLEAR);

  // R10
  recall_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_LOAD) |-> $past(state) == ST_CLEAR && $past(ptr) == PTR_LAST);
endmodule

// File: tb/sim_nvsram_ctl.sv
module sim_nvsram_ctl;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;
  localparam logic [15:0] K0 = 16'h0015, K1 = 16'h000A, K2 = 16'h001B,
                          K3 = 16'h0004, K4 = 16'h0011, KS = 16'h001E, KR = 16'h0009;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] dq_i = '0, dq_o;
  logic dq_oe, busy;
  logic ce_n = 1, oe_n = 1, we_n = 1, pwr_ok = 0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  nvsram_ctl #(.AW(AW), .DW(8), .KEY0(K0), .KEY1(K1), .KEY2(K2), .KEY3(K3),
               .KEY4(K4), .KEY_STORE(KS), .KEY_RECALL(KR)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .pwr_ok(pwr_ok), .busy(busy));

  // {write, addr[4:0], data[7:0]}
  localparam logic [13:0] VEC [8] = '{
    {1'b1, 5'd0,  8'hA5}, {1'b1, 5'd1,  8'h3C}, {1'b1, 5'd31, 8'hFF},
    {1'b0, 5'd0,  8'hA5}, {1'b0, 5'd1,  8'h3C}, {1'b1, 5'd0,  8'h5A},
    {1'b0, 5'd0,  8'h5A}, {1'b0, 5'd31, 8'hFF}};

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ce_n = 1; oe_n = 1; we_n = 1;
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 0; oe_n = 1; we_n = 0; addr = a; dq_i = d;
  endtask

  task automatic rd_nc(input logic [AW-1:0] a);
    @(negedge clk);
    ce_n = 0; oe_n = 0; we_n = 1; addr = a;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    rd_nc(a);
    #1;
    chk(dq_oe === 1'b1 && dq_o === e, tag, {dq_oe, dq_o}, {1'b1, e});
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic prefix();
    rd_nc(K0[AW-1:0]); rd_nc(K1[AW-1:0]); rd_nc(K2[AW-1:0]);
    rd_nc(K3[AW-1:0]); rd_nc(K4[AW-1:0]);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #1;
    chk(busy === 1'b0 && dq_oe === 1'b0, "reset R2", {busy, dq_oe}, 0);
    @(negedge clk); rst_n = 1;
    idle();
    chk(busy === 1'b0, "idle after reset R4", busy, 0);

    // R5: power-up recall
    @(negedge clk); pwr_ok = 1;
    idle();
    wait_busy(n);
    chk(n == 2 * DEPTH, "power-up recall length R5", n, 2 * DEPTH);

    // R1 R2: vector table
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][13]) wr(VEC[i][12:8], VEC[i][7:0]);
      else rd(VEC[i][12:8], VEC[i][7:0], "vector R1 R2");
    end

    // R2: no drive without chip enable
    @(negedge clk); ce_n = 1; oe_n = 0; we_n = 1; addr = 5'd0; #1;
    chk(dq_oe === 1'b0, "ce_n high no drive R2", dq_oe, 0);

    // R3: write priority over output enable
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0; addr = 5'd2; dq_i = 8'h77; #1;
    chk(dq_oe === 1'b0, "write priority R3", dq_oe, 0);
    rd(5'd2, 8'h77, "write priority data R3");

    // R6: software store of pattern
    for (int i = 0; i < DEPTH; i++) wr(5'(i), pat(i));
    prefix(); rd_nc(KS[AW-1:0]);
    idle();
    wait_busy(n);
    chk(n == DEPTH, "software store length R6", n, DEPTH);

    // R7 R10: overwrite then software recall
    for (int i = 0; i < DEPTH; i++) wr(5'(i), ~pat(i));
    prefix(); rd_nc(KR[AW-1:0]);
    idle();
    wait_busy(n);
    chk(n == 2 * DEPTH, "software recall length R7", n, 2 * DEPTH);
    for (int i = 0; i < DEPTH; i++) rd(5'(i), pat(i), "recalled data R10");

    // R10: recall again returns same data
    wr(5'd4, 8'h00);
    prefix(); rd_nc(KR[AW-1:0]);
    idle();
    wait_busy(n);
    rd(5'd4, pat(4), "repeat recall R10");

    // R8: stray write aborts
    rd_nc(K0[AW-1:0]); rd_nc(K1[AW-1:0]); rd_nc(K2[AW-1:0]);
    wr(5'd9, 8'h11);
    rd_nc(K3[AW-1:0]); rd_nc(K4[AW-1:0]); rd_nc(KS[AW-1:0]);
    idle();
    chk(busy === 1'b0, "stray write abort R8", busy, 0);

    // R8: stray read aborts
    rd_nc(K0[AW-1:0]); rd_nc(K1[AW-1:0]); rd_nc(5'd20);
    rd_nc(K2[AW-1:0]); rd_nc(K3[AW-1:0]); rd_nc(K4[AW-1:0]); rd_nc(KS[AW-1:0]);
    idle();
    chk(busy === 1'b0, "stray read abort R8", busy, 0);

    // R8: KEY0 restarts the sequence
    rd_nc(K0[AW-1:0]); rd_nc(K1[AW-1:0]);
    prefix(); rd_nc(KS[AW-1:0]);
    idle();
    wait_busy(n);
    chk(n == DEPTH, "restart on first key R8", n, DEPTH);

    // R4 R9 R11: power store with access and power rise during busy
    @(negedge clk); pwr_ok = 0; ce_n = 1;
    wr(5'd6, 8'hEE); #1;
    chk(busy === 1'b1, "store running R4", busy, 1);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = 5'd6; pwr_ok = 1; #1;
    chk(dq_oe === 1'b0, "no drive while busy R9", dq_oe, 0);
    idle();
    wait_busy(n);
    chk(n + 2 == DEPTH, "power store length R4", n + 2, DEPTH);
    idle(); idle();
    chk(busy === 1'b0, "power rise during busy dropped R11", busy, 0);
    rd(5'd6, pat(6), "write ignored while busy R9");

    // R4 R5: power store and power recall contents
    wr(5'd7, 8'hC3);
    @(negedge clk); ce_n = 1; pwr_ok = 0;
    idle();
    wait_busy(n);
    wr(5'd7, 8'h00);
    rd(5'd7, 8'h00, "overwrite before recall R1");
    @(negedge clk); ce_n = 1; pwr_ok = 1;
    idle();
    wait_busy(n);
    chk(n == 2 * DEPTH, "power recall length R5", n, 2 * DEPTH);
    rd(5'd7, 8'hC3, "power store then recall R4 R5");
    rd(5'd9, 8'h11, "stored word kept R4");

    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule